// File: doc/BRIEF.md
# Byte-wide SPI serial port with status flags

This block is a full-duplex SPI shifter that works as either the clock master or a selected slave. The host reaches it through a single data buffer. In master mode, a write while the port is idle loads the outgoing byte and starts a transfer. In slave mode, the same write preloads the byte that the external master will clock out. The received byte is latched into a read buffer when the last bit has been shifted. Four sticky flags report the transfer: buffer full, write collision, receive overflow and transfer done.

In master mode the serial clock comes from one of two kinds of source. Three select codes give a fixed divide of the system clock. The fourth makes every tick of an external timer produce one SCK half period. A transfer in timer mode waits for a fresh tick before it counts any half period, so the first pulse is never cut short. The output data bit moves only on the shift edge that belongs to the selected clock phase. After the final bit it holds its value until the next write.

Dropping the enable input aborts any transfer, returns SCK to idle and clears every flag. The next enable therefore starts from a clean state.

Top module: `spi_port`

## Requirements
- R1: After reset, `busy`, `buf_full`, `wcol`, `ovf` and `done_irq` are 0, and `sck_o` equals `cpol`.
- R2: A master transfer makes exactly 2*DW transitions on `sck_o`, starting from and ending at the idle level `cpol`, and sends the written byte MSB first. With `cpha`=0, data is sampled on the edges that leave the idle level and `sdo` changes on the edges that return to it. With `cpha`=1 the two roles swap.
- R3: At the end of a transfer, the byte sampled from `sdi` MSB first appears on `rd_data`. `buf_full` and `done_irq` are set together with it.
- R4: With `clk_sel` = 0, 1 or 2, every SCK half period lasts DIV0/2, DIV1/2 or DIV2/2 system clocks (2, 8 and 32 by default).
- R5: With `clk_sel` = 3, every SCK half period equals one interval of `tmr_tick`. Ticks are ignored until the first tick after the starting write. The first SCK edge therefore comes no sooner than one full tick interval after that write.
- R6: A write while `busy` is 1 sets `wcol` and discards the written byte. The transfer in progress finishes with its original data.
- R7: In slave mode, a transfer that completes while `buf_full` is 1 sets `ovf` and leaves `rd_data` unchanged.
- R8: A pulse on `rd_en` clears `buf_full`.
- R9: Pulses on `wcol_clr`, `ovf_clr` and `done_clr` clear `wcol`, `ovf` and `done_irq` respectively. Each flag stays set until it is cleared this way or the port is disabled.
- R10: While `en` is 0, all four flags and `busy` read 0 and `sck_o` sits at `cpol`. A write while `en` is 0 starts nothing.
- R11: While the port is idle and no write arrives, `sdo` keeps its value. After a transfer it holds bit 0 of the byte that was sent.
- R12: In slave mode (`master`=0), the port shifts on transitions of `sck_i` while `ss_n` is low, using the same phase rules as R2. `sck_i`, `sdi` and `ss_n` pass through a two-flop synchroniser. Raising `ss_n` returns the bit count to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Port enable; 0 aborts the transfer and clears all flags |
| master | input | 1 | 1 = drive SCK, 0 = follow external SCK |
| cpol | input | 1 | SCK idle level |
| cpha | input | 1 | 0 = sample on leading edge, 1 = sample on trailing edge |
| clk_sel | input | 2 | Master clock source: 0/1/2 fixed divides, 3 timer ticks |
| tmr_tick | input | 1 | One-cycle timer match pulse |
| wr_en | input | 1 | Host write strobe for the buffer |
| wr_data | input | DW | Byte to transmit |
| rd_en | input | 1 | Host read strobe; clears buffer full |
| rd_data | output | DW | Last received byte |
| wcol_clr | input | 1 | Clears the write-collision flag |
| ovf_clr | input | 1 | Clears the overflow flag |
| done_clr | input | 1 | Clears the transfer-done flag |
| sck_i | input | 1 | Serial clock from an external master |
| ss_n | input | 1 | Slave select, active low |
| sdi | input | 1 | Serial data in |
| sck_o | output | 1 | Serial clock driven in master mode |
| sdo | output | 1 | Serial data out |
| busy | output | 1 | Transfer in progress |
| buf_full | output | 1 | Unread byte in the buffer |
| wcol | output | 1 | Write collision flag |
| ovf | output | 1 | Receive overflow flag |
| done_irq | output | 1 | Transfer-complete interrupt flag |

## Verification
The bench builds the port with its default values: an 8-bit byte and divides of 4, 16 and 64, so every one of the four clock sources is exercised. It also drives a 20-cycle timer tick. Each transfer starts at a random phase of that tick, which brings the first-pulse alignment under test at many offsets. In master mode `sdi` is looped back inverted from `sdo`, so the received byte differs from the sent one. A bench-side slave with its own 6-cycle half period covers all four phase and polarity modes through the synchroniser, including an aborted frame.

// File: rtl/spi_port.sv
module spi_port #(
  parameter int DW   = 8,
  parameter int DIV0 = 4,
  parameter int DIV1 = 16,
  parameter int DIV2 = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          master,
  input  logic          cpol,
  input  logic          cpha,
  input  logic [1:0]    clk_sel,
  input  logic          tmr_tick,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  input  logic          wcol_clr,
  input  logic          ovf_clr,
  input  logic          done_clr,
  input  logic          sck_i,
  input  logic          ss_n,
  input  logic          sdi,
  output logic          sck_o,
  output logic          sdo,
  output logic          busy,
  output logic          buf_full,
  output logic          wcol,
  output logic          ovf,
  output logic          done_irq
);
  localparam int H0 = DIV0 / 2;
  localparam int H1 = DIV1 / 2;
  localparam int H2 = DIV2 / 2;
  localparam int HM = (H0 > H1) ? ((H0 > H2) ? H0 : H2) : ((H1 > H2) ? H1 : H2);
  localparam int CW = $clog2(HM) + 1;
  localparam int EW = $clog2(2 * DW);

  logic          run, armed;
  logic [CW-1:0] div_cnt, half_m1;
  logic [EW-1:0] ecnt;
  logic [DW-1:0] tx_sr, rx_sr, rx_buf;
  logic [2:0]    sck_q;
  logic [1:0]    sdi_q, ss_q;

  always_comb begin
    case (clk_sel)
      2'd0:    half_m1 = CW'(H0 - 1);
      2'd1:    half_m1 = CW'(H1 - 1);
      default: half_m1 = CW'(H2 - 1);
    endcase
  end

  wire tmr_mode = (clk_sel == 2'd3);
  wire hstep    = tmr_mode ? (tmr_tick & armed) : (div_cnt == half_m1);
  wire s_edge   = (sck_q[1] ^ sck_q[2]) & ~ss_q[1];
  wire step     = en & (master ? (run & hstep) : s_edge);
  wire lead     = ~ecnt[0];
  wire last     = (ecnt == EW'(2 * DW - 1));
  wire din      = master ? sdi : sdi_q[1];
  wire samp     = cpha ? ~lead : lead;
  wire shft     = cpha ? (lead & (ecnt != '0)) : (~lead & ~last);
  wire cmpl     = step & last;
  wire active   = master ? run : (ecnt != '0);
  wire wr_ok    = en & wr_en & ~active;
  wire wr_bad   = en & wr_en & active;
  wire drop     = cmpl & ~master & buf_full;
  wire [DW-1:0] rx_nx = samp ? {rx_sr[DW-2:0], din} : rx_sr;

  assign busy    = active;
  assign sdo     = tx_sr[DW-1];
  assign rd_data = rx_buf;
  assign sck_o   = master ? (cpol ^ ecnt[0]) : cpol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= '0; sdi_q <= '0; ss_q <= '1;
      run <= 1'b0; armed <= 1'b0; div_cnt <= '0; ecnt <= '0;
      tx_sr <= '0; rx_sr <= '0; rx_buf <= '0;
      buf_full <= 1'b0; wcol <= 1'b0; ovf <= 1'b0; done_irq <= 1'b0;
    end else begin
      sck_q <= {sck_q[1:0], sck_i};
      sdi_q <= {sdi_q[0], sdi};
      ss_q  <= {ss_q[0], ss_n};
      if (!en) begin
        run <= 1'b0; armed <= 1'b0; div_cnt <= '0; ecnt <= '0;
        buf_full <= 1'b0; wcol <= 1'b0; ovf <= 1'b0; done_irq <= 1'b0;
      end else begin
        if (run) begin
          if (tmr_mode) begin
            if (tmr_tick) armed <= 1'b1;
          end else begin
            div_cnt <= (div_cnt == half_m1) ? '0 : div_cnt + 1'b1;
          end
        end

        if (!master && ss_q[1]) ecnt <= '0;
        else if (step)          ecnt <= last ? '0 : ecnt + 1'b1;

        if (step && samp) rx_sr <= rx_nx;

        if (wr_ok)              tx_sr <= wr_data;
        else if (step && shft)  tx_sr <= {tx_sr[DW-2:0], 1'b0};

        if (wr_ok && master) begin
          run <= 1'b1; armed <= 1'b0; div_cnt <= '0;
        end else if (cmpl) begin
          run <= 1'b0;
        end

        if (cmpl && !drop) begin
          rx_buf   <= rx_nx;
          buf_full <= 1'b1;
        end else if (rd_en) begin
          buf_full <= 1'b0;
        end

        if (cmpl)          done_irq <= 1'b1;
        else if (done_clr) done_irq <= 1'b0;

        if (drop)         ovf <= 1'b1;
        else if (ovf_clr) ovf <= 1'b0;

        if (wr_bad)        wcol <= 1'b1;
        else if (wcol_clr) wcol <= 1'b0;
      end
    end
  end

  // R6
  wcol_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && wr_en && busy) |=> wcol);

  // R8
  rd_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && rd_en && !cmpl) |=> !buf_full);

  // R10
  dis_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!buf_full && !wcol && !ovf && !done_irq && !busy));

  // R3
  done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl |=> (done_irq && buf_full));

  // R11
  sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !wr_en) |=> $stable(sdo));

  // R7
  ovf_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> (ovf && $stable(rd_data)));
endmodule

// File: tb/sim_spi_port.sv
module sim_spi_port;
  localparam int CLK_PERIOD = 10;
  localparam int TP = 20;
  localparam int HS = 6;

  logic clk = 1'b0;
  logic rst_n, en, master, cpol, cpha, tmr_tick, wr_en, rd_en;
  logic wcol_clr, ovf_clr, done_clr, sck_i, ss_n, sdi_b, sdi;
  logic [1:0] clk_sel;
  logic [7:0] wr_data, rd_data;
  logic sck_o, sdo, busy, buf_full, wcol, ovf, done_irq;

  int checks = 0, errors = 0;
  int cyc = 0, wr_cyc = 0, last_cyc = 0, first_gap = 0, gap = 0;
  int mn = 0, mx = 0, mon_edges = 0, tcnt = 0;
  logic [7:0] mon_byte = '0;
  logic sck_prev = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sdi = master ? ~sdo : sdi_b;

  spi_port #(.DW(8)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .master(master), .cpol(cpol), .cpha(cpha),
    .clk_sel(clk_sel), .tmr_tick(tmr_tick), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .wcol_clr(wcol_clr), .ovf_clr(ovf_clr),
    .done_clr(done_clr), .sck_i(sck_i), .ss_n(ss_n), .sdi(sdi), .sck_o(sck_o),
    .sdo(sdo), .busy(busy), .buf_full(buf_full), .wcol(wcol), .ovf(ovf),
    .done_irq(done_irq));

  always @(negedge clk) begin
    if (tcnt == TP - 1) begin tcnt = 0; tmr_tick = 1'b1; end
    else begin tcnt = tcnt + 1; tmr_tick = 1'b0; end
  end

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (sck_o !== sck_prev) begin
      if (mon_edges == 0) first_gap = cyc - wr_cyc;
      else begin
        gap = cyc - last_cyc;
        if (gap < mn) mn = gap;
        if (gap > mx) mx = gap;
      end
      last_cyc = cyc;
      mon_edges = mon_edges + 1;
      if ((sck_o != cpol) ^ cpha) mon_byte = {mon_byte[6:0], sdo};
    end
    sck_prev = sck_o;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cw(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] b);
    wr_data = b; wr_en = 1'b1; @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse_rd();  rd_en = 1'b1;    @(negedge clk); rd_en = 1'b0;    endtask
  task automatic pulse_dc();  done_clr = 1'b1; @(negedge clk); done_clr = 1'b0; endtask
  task automatic pulse_wc();  wcol_clr = 1'b1; @(negedge clk); wcol_clr = 1'b0; endtask
  task automatic pulse_oc();  ovf_clr = 1'b1;  @(negedge clk); ovf_clr = 1'b0;  endtask

  task automatic wait_done();
    int n = 0;
    while (!done_irq && n < 4000) begin @(negedge clk); n++; end
  endtask

  function automatic int half_of(input logic [1:0] s);
    case (s)
      2'd0: return 2;
      2'd1: return 8;
      2'd2: return 32;
      default: return TP;
    endcase
  endfunction

  task automatic mon_reset();
    mon_edges = 0; mon_byte = '0; mn = 1000000; mx = 0; wr_cyc = cyc;
  endtask

  task automatic master_xfer(input logic [7:0] tx, input logic cp, input logic ph, input logic [1:0] sel);
    logic [7:0] exp_rx;
    int h;
    cpol = cp; cpha = ph; clk_sel = sel;
    cw(3);
    pulse_rd(); pulse_dc();
    mon_reset();
    wr(tx);
    wait_done();
    cw(2);
    exp_rx = ~tx;
    h = half_of(sel);
    chk(rd_data == exp_rx, "R3", "rx byte", rd_data, exp_rx);
    chk(buf_full && done_irq, "R3", "full+done", {buf_full, done_irq}, 3);
    chk(mon_byte == tx, "R2", "serial byte", mon_byte, tx);
    chk(mon_edges == 16, "R2", "sck edges", mon_edges, 16);
    if (sel == 2'd3) begin
      chk(mn == h && mx == h, "R5", "tick half period", mx, h);
      chk(first_gap >= TP, "R5", "first edge delay", first_gap, TP);
    end else begin
      chk(mn == h && mx == h, "R4", "half period", mx, h);
    end
    cw(5);
    chk(sdo == tx[0], "R11", "sdo hold", sdo, tx[0]);
    chk(sck_o == cp, "R2", "sck idle", sck_o, cp);
  endtask

  task automatic slave_xfer(input logic [7:0] din, input int nbits, output logic [7:0] got);
    got = '0;
    sck_i = cpol;
    cw(4);
    ss_n = 1'b0;
    cw(HS);
    for (int i = 7; i > 7 - nbits; i--) begin
      if (!cpha) sdi_b = din[i];
      cw(HS);
      sck_i = ~cpol;
      if (cpha) sdi_b = din[i];
      else got = {got[6:0], sdo};
      cw(HS);
      sck_i = cpol;
      if (cpha) got = {got[6:0], sdo};
    end
    cw(HS);
    ss_n = 1'b1;
    cw(6);
  endtask

  initial begin
    logic [7:0] got, a, b;
    void'($urandom(32'h1F2E3D4C));
    rst_n = 1'b0; en = 1'b0; master = 1'b1; cpol = 1'b0; cpha = 1'b0; clk_sel = 2'd0;
    wr_en = 1'b0; rd_en = 1'b0; wr_data = '0; wcol_clr = 1'b0; ovf_clr = 1'b0;
    done_clr = 1'b0; sck_i = 1'b0; ss_n = 1'b1; sdi_b = 1'b0; tmr_tick = 1'b0;
    cw(5); rst_n = 1'b1; cw(2);

    chk(!busy && !buf_full && !wcol && !ovf && !done_irq, "R1", "flags after reset",
        {busy, buf_full, wcol, ovf, done_irq}, 0);
    chk(sck_o == cpol, "R1", "sck after reset", sck_o, cpol);

    en = 1'b1;
    master_xfer(8'hA5, 1'b0, 1'b0, 2'd0);
    master_xfer(8'h3C, 1'b1, 1'b1, 2'd1);
    master_xfer(8'h81, 1'b0, 1'b1, 2'd3);
    master_xfer(8'h7E, 1'b1, 1'b0, 2'd2);
    for (int k = 0; k < 10; k++) begin
      cw($urandom_range(0, TP - 1));
      master_xfer(8'($urandom_range(0, 255)), 1'($urandom_range(0, 1)),
                  1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)));
    end

    // R6 collision during master transfer, R9 clears
    cpol = 1'b0; cpha = 1'b0; clk_sel = 2'd1; cw(3);
    pulse_rd(); pulse_dc(); mon_reset();
    wr(8'hC3);
    cw(20);
    chk(busy == 1'b1, "R6", "busy mid transfer", busy, 1);
    wr(8'h18);
    chk(wcol == 1'b1, "R6", "wcol set", wcol, 1);
    wait_done(); cw(2);
    chk(mon_byte == 8'hC3, "R6", "original byte sent", mon_byte, 8'hC3);
    chk(rd_data == 8'h3C, "R6", "rx of original", rd_data, 8'h3C);
    chk(wcol == 1'b1, "R9", "wcol sticky", wcol, 1);
    pulse_wc();
    chk(wcol == 1'b0, "R9", "wcol cleared", wcol, 0);
    pulse_dc();
    chk(done_irq == 1'b0, "R9", "done cleared", done_irq, 0);
    chk(buf_full == 1'b1, "R8", "full before read", buf_full, 1);
    pulse_rd();
    chk(buf_full == 1'b0, "R8", "read clears full", buf_full, 0);

    // R10 disable mid transfer
    wr(8'h55); cw(4); wr(8'h66); cw(10);
    en = 1'b0; cw(1);
    chk(!busy && !wcol && !buf_full && !done_irq && !ovf, "R10", "disable clears",
        {busy, wcol, buf_full, done_irq, ovf}, 0);
    chk(sck_o == cpol, "R10", "sck idle when off", sck_o, cpol);
    wr(8'h99); cw(40);
    chk(!busy && !done_irq && sck_o == cpol, "R10", "write ignored when off",
        {busy, done_irq}, 0);
    en = 1'b1; cw(2);

    // R12 slave mode
    master = 1'b0; cpol = 1'b0; cpha = 1'b0; cw(4);
    pulse_rd(); pulse_dc();
    wr(8'h4B);
    slave_xfer(8'hD2, 8, got);
    chk(got == 8'h4B, "R12", "slave sdo byte", got, 8'h4B);
    chk(rd_data == 8'hD2, "R12", "slave rx byte", rd_data, 8'hD2);
    chk(buf_full && done_irq, "R3", "slave full+done", {buf_full, done_irq}, 3);

    // R7 overflow
    cpol = 1'b1; cpha = 1'b1; cw(4);
    wr(8'h96);
    slave_xfer(8'h2D, 8, got);
    chk(got == 8'h96, "R12", "slave sdo mode3", got, 8'h96);
    chk(ovf == 1'b1, "R7", "ovf set", ovf, 1);
    chk(rd_data == 8'hD2, "R7", "rx kept", rd_data, 8'hD2);
    pulse_oc();
    chk(ovf == 1'b0, "R9", "ovf cleared", ovf, 0);

    // R12 aborted frame
    pulse_rd(); pulse_dc();
    cpol = 1'b0; cpha = 1'b1; cw(4);
    wr(8'hE7);
    slave_xfer(8'hFF, 3, got);
    chk(!busy && !done_irq, "R12", "abort resets count", {busy, done_irq}, 0);
    wr(8'h5A);
    slave_xfer(8'h69, 8, got);
    chk(got == 8'h5A, "R12", "after abort sdo", got, 8'h5A);
    chk(rd_data == 8'h69, "R12", "after abort rx", rd_data, 8'h69);

    for (int k = 0; k < 4; k++) begin
      a = 8'($urandom_range(0, 255)); b = 8'($urandom_range(0, 255));
      cpol = 1'($urandom_range(0, 1)); cpha = 1'($urandom_range(0, 1)); cw(4);
      pulse_rd(); pulse_dc();
      wr(a);
      slave_xfer(b, 8, got);
      chk(got == a, "R12", "random slave sdo", got, a);
      chk(rd_data == b, "R12", "random slave rx", rd_data, b);
    end

    // R10 disable in slave with full and ovf
    wr(8'h11);
    slave_xfer(8'h22, 8, got);
    chk(ovf && buf_full, "R7", "ovf before disable", {ovf, buf_full}, 3);
    en = 1'b0; cw(1);
    chk(!ovf && !buf_full && !done_irq, "R10", "slave disable clears", {ovf, buf_full, done_irq}, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule